// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block drives a three-wire serial EEPROM that stores 16-bit words. It generates chip select, the serial clock and the serial data line to the device, and it samples the serial data line that comes back. A host asks for a 32-bit read or a 32-bit write at a byte offset. Either request is a one-cycle start pulse. The block answers with a busy level and then a one-cycle done pulse, and it raises an error flag on writes whose completion never shows up.

Each 32-bit access is made of two consecutive device words. The upper half lives at the word the offset names, and the lower half lives at the following word. A size input picks one of three device organisations, and that choice sets the command length and the address field width. A divider input sets how many system clocks make one serial half-period. Each write half is wrapped in an enable command and a disable command, and the block waits for the device to report ready before it sends the disable. The wait is bounded.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `wr_err` and `rd_data` are all zero.
- R2: Before every command, chip select is held low for at least one serial half-period and is then raised.
- R3: Each serial clock high phase lasts exactly `half_div` system clocks, and each low phase lasts at least that long. A `half_div` of 0 acts as 1. `ee_di` never changes while `ee_sk` is high.
- R4: Commands go out MSB first, one bit per serial clock rise. Each command is a start bit of 1, then a 2-bit opcode, then the address field. The opcodes are read 10, write 01, and control 00. For control commands, the top two address bits are 11 for write-enable and 00 for write-disable. The word address is `byte_off[8:1]`. With `cfg_size` = 0 the command is 9 bits with a 6-bit address. With `cfg_size` = 1, 2 or 3 it is 11 bits with an 8-bit address.
- R5: A read sends the read command and then 32 clock pulses. `ee_do` is sampled at the end of each high phase and shifted in MSB first. `rd_data[31:16]` is the word at the offset and `rd_data[15:0]` is the next word, modulo the device size.
- R6: A write stores `wr_data[31:16]` at word w and then `wr_data[15:0]` at word w+1. Each half is sent as write-enable, then write plus address, then 16 data bits MSB first, then write-disable.
- R7: After the data bits of each write half, chip select is dropped and raised again. `ee_do` is then polled once per half-period until it reads 1, or until POLL_LIMIT polls have passed. If either half times out, `wr_err` is 1 with done. Otherwise `wr_err` is 0. `wr_err` changes only with done.
- R8: `busy` is high from the cycle after an accepted start until done. `done` is a one-cycle pulse that comes with `busy` low. A start that arrives while busy is ignored. If both starts arrive together, the read is performed.
- R9: Whenever the block is idle, including the cycle of done, `ee_cs`, `ee_sk` and `ee_di` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 2 | Device organisation: 0 = 64 words, 1 = 128 words, 2/3 = 256 words |
| half_div | input | DIV_W | System clocks per serial half-period (0 acts as 1) |
| rd_start | input | 1 | Start a 32-bit read |
| wr_start | input | 1 | Start a 32-bit write |
| byte_off | input | 9 | Byte offset of the access |
| wr_data | input | 32 | Write data, upper half stored first |
| rd_data | output | 32 | Result of the last read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | Ready-poll timeout on the finished write |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The hardest path to reach from the ports is the ready-poll timeout. A working device always reports ready, so the timeout needs a device that never finishes its write. The bench's device model has a switch that holds its ready line low. With that switch on, a write must wait out the full poll limit on both halves and then report the error. The next access must clear the error. Starts that arrive mid-operation, and simultaneous read and write starts, are also injected on purpose. The bench then confirms that no stray write reached the device and that no second operation followed.

// File: rtl/mw_pkg.sv
// Package: shared types and command builders for the three-wire EEPROM master.
// Assumes 16-bit device words and an address field of at most 8 bits.
package mw_pkg;
    localparam int WORD_W  = 16;
    localparam int WADDR_W = 8;
    localparam int BYTE_W  = WADDR_W + 1;
    localparam int RX_W    = 2 * WORD_W;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_CTRL  = 2'b00;

    // Primitive jobs handed to the serial engine
    typedef enum logic [2:0] {
        K_CMD, K_DATA, K_READ, K_POLL, K_END
    } kind_e;

    // Steps of the operation sequencer
    typedef enum logic [2:0] {
        ST_RCMD, ST_RDAT, ST_WEN, ST_WCMD, ST_WDAT, ST_POLL, ST_WDS, ST_END
    } step_e;

    function automatic logic is_small(input logic [1:0] sz);
        return sz == 2'd0;
    endfunction

    function automatic logic [5:0] cmd_bits(input logic [1:0] sz);
        return is_small(sz) ? 6'd9 : 6'd11;
    endfunction

    // Command word left-aligned in 16 bits: start bit, opcode, address
    function automatic logic [WORD_W-1:0] build_cmd(input logic [1:0] sz,
                                                    input logic [1:0] op,
                                                    input logic [WADDR_W-1:0] addr);
        if (is_small(sz))
            return {1'b1, op, addr[5:0], 7'b0};
        return {1'b1, op, addr, 5'b0};
    endfunction

    // Address field of a control command: top two bits 11 enable, 00 disable
    function automatic logic [WADDR_W-1:0] ctrl_addr(input logic [1:0] sz, input logic en);
        if (is_small(sz))
            return {2'b00, {2{en}}, 4'b0};
        return {{2{en}}, 6'b0};
    endfunction
endpackage

// File: rtl/mw_half_tick.sv
// Half-period tick generator. Emits one tick every half_div clocks
// (0 acts as 1). Restart zeroes the count, so the first tick comes a full
// half-period after a restart. Assumes half_div is steady while not restarting.
module mw_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick = (cnt_q == lim);

    // Count system clocks within one serial half-period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mw_serial_engine.sv
// Serial engine. Runs one primitive job at a time on the three device lines:
// a command (chip-select gap, then bits), raw data bits, read pulses,
// a ready poll (chip-select gap, then sampling), or a release of chip select.
// Bits are taken MSB first from a left-aligned word. ee_do is sampled at the
// end of every high phase. Assumes the tick restarts together with go.
module mw_serial_engine
    import mw_pkg::*;
#(
    parameter int POLL_LIMIT = 20000,
    parameter int POLL_W     = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  kind_e             kind,
    input  logic [5:0]        nbits,
    input  logic [WORD_W-1:0] tx,
    input  logic              ee_do,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic [RX_W-1:0]   rx,
    output logic              fin,
    output logic              timed_out
);
    typedef enum logic [2:0] {E_IDLE, E_GAP, E_LO, E_HI, E_POLL} est_e;

    est_e              st_q;
    kind_e             knd_q;
    logic [WORD_W-1:0] sh_q;
    logic [5:0]        left_q;
    logic [POLL_W-1:0] pcnt_q;
    logic              cs_q, sk_q, fin_q, to_q;
    logic [RX_W-1:0]   rx_q;

    assign cs        = cs_q;
    assign sk        = sk_q;
    assign di        = (st_q == E_LO || st_q == E_HI) && sh_q[WORD_W-1];
    assign rx        = rx_q;
    assign fin       = fin_q;
    assign timed_out = to_q;

    // Job state machine, line drive and input sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= E_IDLE;
            knd_q  <= K_END;
            sh_q   <= '0;
            left_q <= '0;
            pcnt_q <= '0;
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            fin_q  <= 1'b0;
            to_q   <= 1'b0;
            rx_q   <= '0;
        end else begin
            fin_q <= 1'b0;
            case (st_q)
                E_IDLE: if (go) begin
                    knd_q  <= kind;
                    sh_q   <= (kind == K_READ) ? '0 : tx;
                    left_q <= nbits;
                    pcnt_q <= '0;
                    to_q   <= 1'b0;
                    case (kind)
                        K_CMD, K_POLL: begin
                            cs_q <= 1'b0;
                            st_q <= E_GAP;
                        end
                        K_END: begin
                            cs_q  <= 1'b0;
                            fin_q <= 1'b1;
                        end
                        default: st_q <= E_LO;
                    endcase
                end
                E_GAP: if (tick) begin
                    cs_q <= 1'b1;
                    st_q <= (knd_q == K_POLL) ? E_POLL : E_LO;
                end
                E_LO: if (tick) begin
                    sk_q <= 1'b1;
                    st_q <= E_HI;
                end
                E_HI: if (tick) begin
                    sk_q   <= 1'b0;
                    rx_q   <= {rx_q[RX_W-2:0], ee_do};
                    sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                    if (left_q == 6'd1) begin
                        st_q  <= E_IDLE;
                        fin_q <= 1'b1;
                    end else begin
                        st_q <= E_LO;
                    end
                end
                E_POLL: if (tick) begin
                    if (ee_do) begin
                        st_q  <= E_IDLE;
                        fin_q <= 1'b1;
                    end else if (pcnt_q == POLL_W'(POLL_LIMIT - 1)) begin
                        st_q  <= E_IDLE;
                        fin_q <= 1'b1;
                        to_q  <= 1'b1;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    // R4: the serial clock only pulses while the device is selected
    a_r4_clock_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        sk_q |-> cs_q);

    // R3: data to the device holds still through every high phase
    a_r3_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_q && $past(sk_q)) |-> $stable(di));
endmodule

// File: rtl/mw_eeprom_master.sv
// Three-wire EEPROM word master (top). Accepts 32-bit read and write requests
// and sequences them as engine jobs. Read: command, 32 pulses, release.
// Write, per 16-bit half: enable, write command, data, ready poll, disable;
// then release. Assumes byte_off, wr_data, cfg_size and half_div are valid
// in the start cycle; they are latched there.
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int POLL_LIMIT = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              rd_start,
    input  logic              wr_start,
    input  logic [BYTE_W-1:0] byte_off,
    input  logic [RX_W-1:0]   wr_data,
    output logic [RX_W-1:0]   rd_data,
    output logic              busy,
    output logic              done,
    output logic              wr_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    step_e              step_q, step_n;
    kind_e              kind_c;
    logic [5:0]         nbits_c;
    logic [WORD_W-1:0]  tx_c;
    logic [1:0]         size_q;
    logic [DIV_W-1:0]   hd_q;
    logic [WADDR_W-1:0] word_q, cur_word;
    logic [RX_W-1:0]    data_q, rd_q;
    logic               busy_q, done_q, err_q, err_acc_q;
    logic               half_q, issue_q, go_q;
    logic               tick, fin, timed_out;
    logic [RX_W-1:0]    rx;

    assign rd_data  = rd_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign wr_err   = err_q;
    assign cur_word = word_q + WADDR_W'(half_q);

    // Job description for the current step
    always_comb begin
        kind_c  = K_END;
        nbits_c = '0;
        tx_c    = '0;
        case (step_q)
            ST_RCMD: begin
                kind_c  = K_CMD;
                nbits_c = cmd_bits(size_q);
                tx_c    = build_cmd(size_q, OPC_READ, word_q);
            end
            ST_RDAT: begin
                kind_c  = K_READ;
                nbits_c = 6'(RX_W);
            end
            ST_WEN: begin
                kind_c  = K_CMD;
                nbits_c = cmd_bits(size_q);
                tx_c    = build_cmd(size_q, OPC_CTRL, ctrl_addr(size_q, 1'b1));
            end
            ST_WCMD: begin
                kind_c  = K_CMD;
                nbits_c = cmd_bits(size_q);
                tx_c    = build_cmd(size_q, OPC_WRITE, cur_word);
            end
            ST_WDAT: begin
                kind_c  = K_DATA;
                nbits_c = 6'(WORD_W);
                tx_c    = half_q ? data_q[WORD_W-1:0] : data_q[RX_W-1:WORD_W];
            end
            ST_POLL: kind_c = K_POLL;
            ST_WDS: begin
                kind_c  = K_CMD;
                nbits_c = cmd_bits(size_q);
                tx_c    = build_cmd(size_q, OPC_CTRL, ctrl_addr(size_q, 1'b0));
            end
            default: kind_c = K_END;
        endcase
    end

    // Step order of read and write operations
    always_comb begin
        case (step_q)
            ST_RCMD: step_n = ST_RDAT;
            ST_RDAT: step_n = ST_END;
            ST_WEN:  step_n = ST_WCMD;
            ST_WCMD: step_n = ST_WDAT;
            ST_WDAT: step_n = ST_POLL;
            ST_POLL: step_n = ST_WDS;
            ST_WDS:  step_n = half_q ? ST_END : ST_WEN;
            default: step_n = ST_END;
        endcase
    end

    // Request acceptance, step sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= ST_END;
            size_q    <= '0;
            hd_q      <= '0;
            word_q    <= '0;
            data_q    <= '0;
            rd_q      <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            err_acc_q <= 1'b0;
            half_q    <= 1'b0;
            issue_q   <= 1'b0;
            go_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            go_q   <= 1'b0;
            if (!busy_q) begin
                if (rd_start || wr_start) begin
                    busy_q    <= 1'b1;
                    step_q    <= rd_start ? ST_RCMD : ST_WEN;
                    size_q    <= cfg_size;
                    hd_q      <= half_div;
                    word_q    <= byte_off[BYTE_W-1:1];
                    data_q    <= wr_data;
                    half_q    <= 1'b0;
                    err_acc_q <= 1'b0;
                    issue_q   <= 1'b1;
                end
            end else if (issue_q) begin
                go_q    <= 1'b1;
                issue_q <= 1'b0;
            end else if (fin) begin
                if (step_q == ST_RDAT)
                    rd_q <= rx;
                if (step_q == ST_POLL && timed_out)
                    err_acc_q <= 1'b1;
                if (step_q == ST_WDS)
                    half_q <= 1'b1;
                if (step_q == ST_END) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= err_acc_q;
                end else begin
                    step_q  <= step_n;
                    issue_q <= 1'b1;
                end
            end
        end
    end

    mw_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (go_q || !busy_q),
        .half_div (hd_q),
        .tick     (tick)
    );

    mw_serial_engine #(.POLL_LIMIT(POLL_LIMIT), .POLL_W(POLL_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go        (go_q),
        .kind      (kind_c),
        .nbits     (nbits_c),
        .tx        (tx_c),
        .ee_do     (ee_do),
        .cs        (ee_cs),
        .sk        (ee_sk),
        .di        (ee_di),
        .rx        (rx),
        .fin       (fin),
        .timed_out (timed_out)
    );

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: busy only ends through done
    a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

    // R9: device lines are quiet whenever the block is idle
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!ee_cs && !ee_sk && !ee_di));

    // R7: the error flag moves only with done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_q) |-> done_q);
endmodule

// File: tb/mw_eeprom_master_bench.sv
`timescale 1ns/1ps
module mw_eeprom_master_bench;
    localparam int PL = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size = '0;
    logic [7:0]  half_div = 8'd1;
    logic        rd_start = 1'b0, wr_start = 1'b0;
    logic [8:0]  byte_off = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, done, wr_err, ee_cs, ee_sk, ee_di, ee_do;

    int errors = 0, checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mw_eeprom_master #(.DIV_W(8), .POLL_LIMIT(PL)) u_mw_eeprom_master (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .half_div(half_div),
        .rd_start(rd_start), .wr_start(wr_start), .byte_off(byte_off),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
        .wr_err(wr_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- device model ----------------
    logic [15:0] mem [256];
    logic [1:0]  msize = '0;
    logic        stuck = 1'b0;
    logic        wen = 1'b0, out_mode = 1'b0, out_bit = 1'b0, wr_pending = 1'b0;
    logic [15:0] cmd = '0, dbuf = '0;
    int bcnt = 0, dcnt = 0, obit = 0, raddr = 0, waddr = 0;
    int busy_until = 0, nwrites = 0, bad_wr = 0, fmt_bad = 0;
    int lidx = 0;
    int log_op [16];
    int log_ad [16];
    logic ready_now;

    assign ready_now = !stuck && (cyc >= busy_until);
    assign ee_do     = out_mode ? out_bit : ready_now;

    function automatic int msk(input logic [1:0] s);
        return (s == 2'd0) ? 63 : (s == 2'd1) ? 127 : 255;
    endfunction

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            if (wr_pending && dcnt == 16) begin
                if (wen) begin
                    mem[waddr] = dbuf;
                    nwrites++;
                    busy_until = cyc + 40;
                end else bad_wr++;
            end
            wr_pending = 1'b0; out_mode = 1'b0; bcnt = 0; dcnt = 0; cmd = '0;
        end else if (out_mode) begin
            out_bit = mem[raddr][15 - obit];
            obit++;
            if (obit == 16) begin obit = 0; raddr = (raddr + 1) & msk(msize); end
        end else if (wr_pending) begin
            if (dcnt < 16) begin dbuf = {dbuf[14:0], ee_di}; dcnt++; end
        end else begin
            int clen, ad;
            logic [1:0] op, top;
            clen = (msize == 2'd0) ? 9 : 11;
            cmd = {cmd[14:0], ee_di};
            bcnt++;
            if (bcnt == clen) begin
                if (!cmd[clen-1]) fmt_bad++;
                op  = cmd[clen-2 -: 2];
                ad  = ((msize == 2'd0) ? int'(cmd[5:0]) : int'(cmd[7:0])) & msk(msize);
                top = (msize == 2'd0) ? cmd[5:4] : cmd[7:6];
                if (op == 2'b10) begin
                    out_mode = 1'b1; obit = 0; raddr = ad; out_bit = 1'b0;
                    log_op[lidx] = 1; log_ad[lidx] = ad; lidx++;
                end else if (op == 2'b01) begin
                    wr_pending = 1'b1; dcnt = 0; waddr = ad;
                    log_op[lidx] = 2; log_ad[lidx] = ad; lidx++;
                end else if (op == 2'b00 && top == 2'b11) begin
                    wen = 1'b1; log_op[lidx] = 3; log_ad[lidx] = 0; lidx++;
                end else if (op == 2'b00 && top == 2'b00) begin
                    wen = 1'b0; log_op[lidx] = 4; log_ad[lidx] = 0; lidx++;
                end else fmt_bad++;
                if (lidx > 15) lidx = 15;
            end
        end
    end

    // ---------------- line timing monitor ----------------
    int exp_hd = 1, hi_run = 0, lo_run = 1000, cs_lo = 1000;
    int sk_bad = 0, di_bad = 0, gap_bad = 0;
    logic prev_sk = 1'b0, prev_di = 1'b0, prev_cs = 1'b0;

    always @(negedge clk) begin
        if (ee_sk) begin
            if (!prev_sk && lo_run < exp_hd) sk_bad++;
            if (prev_sk && ee_di != prev_di) di_bad++;
            hi_run = prev_sk ? hi_run + 1 : 1;
        end else begin
            if (prev_sk && hi_run != exp_hd) sk_bad++;
            lo_run = prev_sk ? 1 : lo_run + 1;
        end
        if (ee_cs && !prev_cs) begin
            if (cs_lo < exp_hd) gap_bad++;
            cs_lo = 0;
        end else if (!ee_cs) cs_lo++;
        prev_sk = ee_sk; prev_di = ee_di; prev_cs = ee_cs;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [31:0] last_rd;
    logic        last_err;
    int          op_cycles;

    task automatic do_op(input bit rd, input bit wr, input bit poke, input logic [1:0] sz,
                         input logic [7:0] hd, input logic [8:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_size = sz; msize = sz; half_div = hd; exp_hd = (hd == 0) ? 1 : int'(hd);
        byte_off = off; wr_data = d; rd_start = rd; wr_start = wr; lidx = 0;
        @(negedge clk);
        rd_start = 1'b0; wr_start = 1'b0; op_cycles = 1;
        chk(busy == 1'b1, "R8 busy after start", {31'b0, busy}, 32'd1);
        while (!done) begin
            @(negedge clk);
            op_cycles++;
            wr_start = (poke && op_cycles == 20);
            if (poke && op_cycles == 20) wr_data = ~d;
        end
        wr_start = 1'b0;
        last_rd = rd_data; last_err = wr_err;
        chk({busy, ee_cs, ee_sk, ee_di} == 4'b0, "R9 lines low at done",
            {28'b0, busy, ee_cs, ee_sk, ee_di}, 32'd0);
        @(negedge clk);
        chk(!done, "R8 done single cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic read_chk(input logic [1:0] sz, input logic [7:0] hd, input logic [8:0] off, input string tag);
        int w, m;
        logic [31:0] exp;
        m = msk(sz); w = int'(off[8:1]);
        exp = {mem[w & m], mem[(w + 1) & m]};
        do_op(1'b1, 1'b0, 1'b0, sz, hd, off, '0);
        chk(last_rd == exp, tag, last_rd, exp);
        chk(lidx == 1 && log_op[0] == 1 && log_ad[0] == (w & m), "R4 read command decoded",
            log_ad[0], w & m);
    endtask

    task automatic write_chk(input logic [1:0] sz, input logic [7:0] hd, input logic [8:0] off, input logic [31:0] d);
        int w, m, n0, b0;
        m = msk(sz); w = int'(off[8:1]); n0 = nwrites; b0 = bad_wr;
        do_op(1'b0, 1'b1, 1'b0, sz, hd, off, d);
        chk({mem[w & m], mem[(w + 1) & m]} == d, "R6 write halves stored",
            {mem[w & m], mem[(w + 1) & m]}, d);
        chk(lidx == 6 && log_op[0] == 3 && log_op[1] == 2 && log_op[2] == 4 &&
            log_op[3] == 3 && log_op[4] == 2 && log_op[5] == 4 &&
            log_ad[1] == (w & m) && log_ad[4] == ((w + 1) & m),
            "R6 enable-write-disable order", lidx, 6);
        chk(nwrites == n0 + 2 && bad_wr == b0 && !wen, "R6 enabled writes then disabled",
            nwrites - n0, 2);
        chk(last_err == 1'b0, "R7 no error when device ready", {31'b0, last_err}, 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({ee_cs, ee_sk, ee_di, busy, done, wr_err} == 6'b0, "R1 outputs idle after reset",
            {26'b0, ee_cs, ee_sk, ee_di, busy, done, wr_err}, 32'd0);
        chk(rd_data == 32'd0, "R1 read data cleared", rd_data, 32'd0);

        // R5/R4 directed reads, including wrap at the top of each size
        read_chk(2'd0, 8'd1, 9'd0, "R5 read small at zero");
        read_chk(2'd0, 8'd2, 9'd126, "R5 read small wraps");
        read_chk(2'd1, 8'd1, 9'd254, "R5 read mid wraps");
        read_chk(2'd2, 8'd3, 9'd510, "R5 read large wraps");
        read_chk(2'd3, 8'd0, 9'd77, "R3 read with zero divider");

        // R6 directed writes at wrap points
        write_chk(2'd0, 8'd1, 9'd126, 32'hA5C3_0F1E);
        read_chk(2'd0, 8'd1, 9'd126, "R5 readback after wrap write");
        write_chk(2'd2, 8'd2, 9'd510, 32'h8001_7FFE);

        // Random mix
        for (int k = 0; k < 14; k++) begin
            logic [1:0] sz;
            logic [7:0] hd;
            logic [8:0] off;
            sz  = 2'($urandom_range(0, 3));
            hd  = 8'($urandom_range(1, 3));
            off = 9'($urandom_range(0, 511));
            if ($urandom_range(0, 1) == 1) begin
                write_chk(sz, hd, off, $urandom);
                read_chk(sz, hd, off, "R5 random readback");
            end else begin
                read_chk(sz, hd, off, "R5 random read");
            end
        end

        // R8: a write start during a read is ignored
        begin
            int n0;
            logic [31:0] exp;
            n0 = nwrites;
            exp = {mem[20], mem[21]};
            do_op(1'b1, 1'b0, 1'b1, 2'd2, 8'd2, 9'd40, 32'h1234_5678);
            chk(last_rd == exp, "R8 read intact despite start while busy", last_rd, exp);
            chk(nwrites == n0, "R8 start while busy did not write", nwrites - n0, 0);
            repeat (10) @(negedge clk);
            chk(!busy, "R8 no queued operation", {31'b0, busy}, 32'd0);
        end

        // R8: simultaneous starts give a read
        begin
            int n0;
            logic [31:0] exp;
            n0 = nwrites;
            exp = {mem[7], mem[8]};
            do_op(1'b1, 1'b1, 1'b0, 2'd1, 8'd1, 9'd14, 32'hDEAD_BEEF);
            chk(last_rd == exp && nwrites == n0, "R8 read wins over write", last_rd, exp);
        end

        // R7: ready never comes, both halves time out
        stuck = 1'b1;
        do_op(1'b0, 1'b1, 1'b0, 2'd2, 8'd1, 9'd100, 32'h0BAD_F00D);
        chk(last_err == 1'b1, "R7 timeout flags error", {31'b0, last_err}, 32'd1);
        chk(op_cycles >= 2 * PL, "R7 full poll window waited", op_cycles, 2 * PL);
        stuck = 1'b0;
        busy_until = 0;
        read_chk(2'd2, 8'd1, 9'd100, "R7 data written despite timeout");
        chk(last_err == 1'b0, "R7 error cleared on next operation", {31'b0, last_err}, 32'd0);

        // Line timing and format monitors
        chk(gap_bad == 0, "R2 select gap before each command", gap_bad, 0);
        chk(sk_bad == 0, "R3 clock phase lengths", sk_bad, 0);
        chk(di_bad == 0, "R3 data steady while clock high", di_bad, 0);
        chk(fmt_bad == 0, "R4 start bit and opcodes valid", fmt_bad, 0);
        chk(bad_wr == 0, "R6 no write without enable", bad_wr, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule